// File: doc/BRIEF.md
# Multi-Word Queue Entry Sequencer

This block decides, one bus beat at a time, whether a word access into a hardware queue is actually carried out. A queue can hold entries of one, two or four 32-bit words. Each queue has a small window of four word slots, and the bus addresses one slot per beat. The sequencer checks each beat against several things: the queue's entry size, the position of the beat inside the current bus burst, the queue's empty or full status, and the progress already made through the entry. It drops every beat that breaks the rules. It asks the pointer engine to advance only after the last word of a complete, in-order entry has gone through.

Decisions are combinational on the beat. Each queue keeps its own sequence state: a busy flag, the transfer direction and the next expected word. This state changes on the clock edge that ends the beat, so a host may interleave partial transfers on different queues. A read beat that is dropped is flagged so that the data path returns zeros in its place.

Top module: `qent_seq`

## Requirements
- R1: The entry size code selects the words per entry: 0 gives 1 word, 1 gives 2 words, 2 gives 4 words. Code 3 is unsupported, and no beat to such a queue is performed.
- R2: A beat whose word slot (`acc_word`, which is byte offset bits [3:2]) is not below the entry's word count is not performed and leaves that queue's sequence state unchanged.
- R3: A beat at slot 0 is performed only if it is a read of a non-empty queue or a write to a non-full queue. A slot-0 beat that passes the size and burst checks always restarts the queue's sequence and throws away any partial progress, even when the status check rejects it.
- R4: A beat at a slot above 0 is performed only if that queue's previous performed word was the slot just below it, in the same direction and within the same unfinished entry. Any other such beat is dropped and leaves the progress unchanged.
- R5: `entry_advance` is high in exactly the cycle in which the last word of an entry is performed (for one-word entries, the slot-0 word). In that cycle `advance_write` gives the direction, with 1 meaning write. Both are low at all other times.
- R6: An entry that is only partly transferred never raises `entry_advance`. After a restart at slot 0, the entry must again be completed from the beginning.
- R7: A beat with `acc_burst_cont` high takes burst position n, where n is the number of beats since the last beat with `acc_burst_cont` low. The beat with `acc_burst_cont` low is at position 0. A beat whose position is not below the entry's word count is not performed and changes no state.
- R8: `read_zero` is high in the cycle of a read beat that is not performed, and low for performed reads, for all writes and when there is no beat.
- R9: Each queue's sequence progress is independent, so beats to other queues in between do not disturb it.
- R10: After reset every queue is idle and the burst position is 0. With `acc_valid` low, all outputs are 0. `word_idx` equals the slot of a performed beat and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A word beat is presented this cycle |
| acc_queue | input | QW | Queue number of the beat |
| acc_word | input | 2 | Word slot in the queue window (byte offset bits [3:2]) |
| acc_write | input | 1 | 1 = write beat, 0 = read beat |
| acc_burst_cont | input | 1 | Beat continues the burst of the previous beat |
| entry_size | input | 2 | Entry size code of the addressed queue |
| q_empty | input | 1 | Addressed queue is empty |
| q_full | input | 1 | Addressed queue is full |
| word_perform | output | 1 | The beat is carried out |
| word_idx | output | 2 | Word index of the performed beat, else 0 |
| entry_advance | output | 1 | Advance the read or write pointer now |
| advance_write | output | 1 | Direction of the advance (1 = write pointer) |
| read_zero | output | 1 | Substitute zero data for this read beat |

## Verification
All five outputs are due in the same cycle as the beat that causes them, with no register in the path. The effect of a beat on sequence state and burst position shows up only in the decisions for beats after the next rising edge. The bench drives each beat just after a falling edge and compares the outputs 2 ns later, before the rising edge. It then advances its own arithmetic model of each queue's progress and of the burst position, so every beat is compared against state made up only of earlier beats.

// File: rtl/qent_seq_pkg.sv
package qent_seq_pkg;

  localparam int WIDX_W = 2;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2,
    SZ_BAD  = 2'd3
  } esize_t;

  typedef struct packed {
    logic              busy;
    logic              wr;
    logic [WIDX_W-1:0] next;
  } seqst_t;

  // number of words in one entry for a size code (0 for unsupported)
  function automatic logic [2:0] words_of(input logic [1:0] code);
    case (code)
      SZ_ONE:  return 3'd1;
      SZ_TWO:  return 3'd2;
      SZ_FOUR: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // slot lies inside the entry
  function automatic logic slot_ok(input logic [1:0] code, input logic [WIDX_W-1:0] idx);
    return {1'b0, idx} < words_of(code);
  endfunction

  // slot is the final word of the entry
  function automatic logic slot_last(input logic [1:0] code, input logic [WIDX_W-1:0] idx);
    return ({1'b0, idx} + 3'd1) == words_of(code);
  endfunction

endpackage

// File: rtl/qent_burst_pos.sv
module qent_burst_pos #(
  parameter int BCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           beat,
  input  logic           cont,
  output logic [BCW-1:0] pos
);
  localparam logic [BCW-1:0] CMAX = {BCW{1'b1}};

  logic [BCW-1:0] cnt_r;

  assign pos = cont ? cnt_r : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else if (beat) begin
      cnt_r <= (pos == CMAX) ? CMAX : pos + 1'b1;
    end
  end
endmodule

// File: rtl/qent_state_bank.sv
module qent_state_bank
  import qent_seq_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] sel_q,
  output seqst_t        sel_st,
  input  logic          upd_en,
  input  seqst_t        upd_st
);
  seqst_t st_r [NQ];

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_q
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_r[g] <= '0;
        end else if (upd_en && (sel_q == QW'(g))) begin
          st_r[g] <= upd_st;
        end
      end
    end
  endgenerate

  assign sel_st = st_r[sel_q];
endmodule

// File: rtl/qent_decide.sv
module qent_decide
  import qent_seq_pkg::*;
#(
  parameter int BCW = 3
) (
  input  logic              valid,
  input  logic [WIDX_W-1:0] idx,
  input  logic              wr,
  input  logic [1:0]        code,
  input  logic [BCW-1:0]    pos,
  input  seqst_t            st,
  input  logic              empty,
  input  logic              full,
  output logic              perform,
  output logic              adv,
  output logic              zero_rd,
  output logic              st_we,
  output seqst_t            st_nxt,
  output logic              ev_size_bad,
  output logic              ev_slot_bad,
  output logic              ev_beat_over,
  output logic              ev_stat_bad,
  output logic              ev_order_bad
);
  logic       lead;
  logic       last;
  logic       gate;
  logic [2:0] nw;

  always_comb begin
    nw           = words_of(code);
    lead         = (idx == '0);
    last         = slot_last(code, idx);
    ev_size_bad  = valid && (code == SZ_BAD);
    ev_slot_bad  = valid && !ev_size_bad && !slot_ok(code, idx);
    ev_beat_over = valid && !ev_size_bad && (int'(pos) >= int'(nw));
    ev_stat_bad  = valid && lead && (wr ? full : empty);
    ev_order_bad = valid && !lead &&
                   !(st.busy && (st.next == idx) && (st.wr == wr));
    gate         = valid && !ev_size_bad && !ev_slot_bad && !ev_beat_over;
    perform      = gate && (lead ? !ev_stat_bad : !ev_order_bad);
    adv          = perform && last;
    zero_rd      = valid && !wr && !perform;

    st_we  = 1'b0;
    st_nxt = st;
    if (gate && lead) begin
      st_we       = 1'b1;
      st_nxt.busy = !ev_stat_bad && !last;
      st_nxt.wr   = wr;
      st_nxt.next = WIDX_W'(1);
    end else if (perform) begin
      st_we       = 1'b1;
      st_nxt.busy = !last;
      st_nxt.wr   = wr;
      st_nxt.next = idx + 1'b1;
    end
  end
endmodule

// File: rtl/qent_seq.sv
module qent_seq
  import qent_seq_pkg::*;
#(
  parameter int NQ  = 8,
  parameter int BCW = 3,
  parameter int QW  = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [QW-1:0] acc_queue,
  input  logic [1:0]    acc_word,
  input  logic          acc_write,
  input  logic          acc_burst_cont,
  input  logic [1:0]    entry_size,
  input  logic          q_empty,
  input  logic          q_full,
  output logic          word_perform,
  output logic [1:0]    word_idx,
  output logic          entry_advance,
  output logic          advance_write,
  output logic          read_zero
);
  logic [BCW-1:0] beat_pos;
  seqst_t         cur_st;
  seqst_t         nxt_st;
  logic           st_we;
  logic           perf_w;
  logic           adv_w;
  logic           zr_w;
  logic           ev_size_bad;
  logic           ev_slot_bad;
  logic           ev_beat_over;
  logic           ev_stat_bad;
  logic           ev_order_bad;

  qent_burst_pos #(.BCW(BCW)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (acc_valid),
    .cont  (acc_burst_cont),
    .pos   (beat_pos)
  );

  qent_state_bank #(.NQ(NQ), .QW(QW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_q  (acc_queue),
    .sel_st (cur_st),
    .upd_en (st_we),
    .upd_st (nxt_st)
  );

  qent_decide #(.BCW(BCW)) u_dec (
    .valid        (acc_valid),
    .idx          (acc_word),
    .wr           (acc_write),
    .code         (entry_size),
    .pos          (beat_pos),
    .st           (cur_st),
    .empty        (q_empty),
    .full         (q_full),
    .perform      (perf_w),
    .adv          (adv_w),
    .zero_rd      (zr_w),
    .st_we        (st_we),
    .st_nxt       (nxt_st),
    .ev_size_bad  (ev_size_bad),
    .ev_slot_bad  (ev_slot_bad),
    .ev_beat_over (ev_beat_over),
    .ev_stat_bad  (ev_stat_bad),
    .ev_order_bad (ev_order_bad)
  );

  assign word_perform  = perf_w;
  assign word_idx      = perf_w ? acc_word : 2'd0;
  assign entry_advance = adv_w;
  assign advance_write = adv_w & acc_write;
  assign read_zero     = zr_w;
endmodule

// File: rtl/qent_seq_chk.sv
module qent_seq_chk #(
  parameter int QW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [QW-1:0] acc_queue,
  input logic [1:0]    acc_word,
  input logic          acc_write,
  input logic [1:0]    entry_size,
  input logic          q_empty,
  input logic          q_full,
  input logic          word_perform,
  input logic          entry_advance,
  input logic          advance_write,
  input logic          read_zero,
  input logic          ev_beat_over,
  input logic          ev_order_bad
);
  // R1
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && entry_size == 2'd3) |-> !word_perform);
  // R2
  one_word_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && entry_size == 2'd0 && acc_word != 2'd0) |-> !word_perform);
  // R3
  lead_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_perform && acc_word == 2'd0) |-> (acc_write ? !q_full : !q_empty));
  // R4
  order_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_order_bad |-> !word_perform);
  // R5
  adv_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_advance |-> (word_perform && advance_write == acc_write));
  // R5
  four_word_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_advance && entry_size == 2'd2) |-> acc_word == 2'd3);
  // R7
  burst_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat_over |-> !word_perform);
  // R8
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_zero |-> (acc_valid && !acc_write && !word_perform));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!word_perform && !entry_advance && !read_zero && !advance_write));
  // R9
  queue_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !$isunknown(acc_queue));
endmodule

bind qent_seq qent_seq_chk #(.QW(QW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_queue     (acc_queue),
  .acc_word      (acc_word),
  .acc_write     (acc_write),
  .entry_size    (entry_size),
  .q_empty       (q_empty),
  .q_full        (q_full),
  .word_perform  (word_perform),
  .entry_advance (entry_advance),
  .advance_write (advance_write),
  .read_zero     (read_zero),
  .ev_beat_over  (ev_beat_over),
  .ev_order_bad  (ev_order_bad)
);

// File: tb/sim_qent_seq.sv
`timescale 1ns/1ps
module sim_qent_seq;
  localparam int NQ = 4;
  localparam int QW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [QW-1:0] acc_queue = '0;
  logic [1:0]    acc_word = '0;
  logic          acc_write = 1'b0;
  logic          acc_burst_cont = 1'b0;
  logic [1:0]    entry_size = '0;
  logic          q_empty = 1'b0;
  logic          q_full = 1'b0;
  logic          word_perform;
  logic [1:0]    word_idx;
  logic          entry_advance;
  logic          advance_write;
  logic          read_zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  bit m_busy [NQ];
  bit m_dir  [NQ];
  int m_next [NQ];
  int m_cnt;
  int cfg    [NQ];
  int adv_seen;
  int seed = 32'h1d2c3b4a;

  always #4 clk = ~clk;

  qent_seq #(.NQ(NQ), .BCW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_queue(acc_queue),
    .acc_word(acc_word), .acc_write(acc_write), .acc_burst_cont(acc_burst_cont),
    .entry_size(entry_size), .q_empty(q_empty), .q_full(q_full),
    .word_perform(word_perform), .word_idx(word_idx), .entry_advance(entry_advance),
    .advance_write(advance_write), .read_zero(read_zero)
  );

  function automatic int nwords(int code);
    return (code == 3) ? 0 : (1 << code);
  endfunction

  function automatic int rnd(int m);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffff) % m;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NQ; i++) begin
      m_busy[i] = 0; m_dir[i] = 0; m_next[i] = 0;
    end
    m_cnt = 0;
  endtask

  task automatic beat(int q, int off, int wr, int cont, int sz, int emp, int ful, string force_tag);
    int w, pos, gate, p, a;
    string tag;
    @(negedge clk);
    acc_valid = 1; acc_queue = QW'(q); acc_word = 2'(off); acc_write = wr[0];
    acc_burst_cont = cont[0]; entry_size = 2'(sz); q_empty = emp[0]; q_full = ful[0];
    w    = nwords(sz);
    pos  = cont ? m_cnt : 0;
    gate = (w > 0) && (off < w) && (pos < w);
    if (off == 0) p = gate && !(wr ? ful : emp);
    else p = gate && m_busy[q] && (m_next[q] == off) && (m_dir[q] == wr);
    a = p && (off == w - 1);
    if (force_tag != "") tag = force_tag;
    else if (a) tag = "R5";
    else if (w == 0) tag = "R1";
    else if (off >= w) tag = "R2";
    else if (pos >= w) tag = "R7";
    else if (off == 0) tag = "R3";
    else tag = "R4";
    #2;
    cmp(tag, "perform", word_perform, p);
    cmp("R5", "advance", entry_advance, a);
    cmp("R5", "adv_dir", advance_write, a && wr);
    cmp("R8", "read_zero", read_zero, !wr && !p);
    cmp("R10", "word_idx", word_idx, p ? off : 0);
    if (a) adv_seen++;
    // model update for the next beat
    if (gate && off == 0) begin
      m_busy[q] = p && (w > 1); m_dir[q] = wr[0]; m_next[q] = 1;
    end else if (p) begin
      m_busy[q] = (off != w - 1); m_dir[q] = wr[0]; m_next[q] = off + 1;
    end
    m_cnt = (pos >= 7) ? 7 : pos + 1;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    acc_valid = 0; acc_write = 1; acc_burst_cont = 0;
    #2;
    cmp("R10", "idle_out",
        {word_perform, entry_advance, advance_write, read_zero, word_idx}, 0);
  endtask

  initial begin
    model_reset();
    for (int i = 0; i < NQ; i++) cfg[i] = i % 3;
    repeat (3) @(posedge clk);
    #1;
    cmp("R10", "reset_out", {word_perform, entry_advance, read_zero}, 0);
    rst_n = 1;
    idle_chk();

    // R10: first beat after reset, slot 1 must be dropped (idle sequence)
    beat(0, 1, 0, 0, 2, 0, 0, "R10");

    // R6: partial four-word read, then restart, then full entry
    adv_seen = 0;
    beat(2, 0, 0, 0, 2, 0, 0, "R6");
    beat(2, 1, 0, 1, 2, 0, 0, "R6");
    beat(2, 0, 0, 0, 2, 0, 0, "R6");
    beat(2, 2, 0, 0, 2, 0, 0, "R6");
    cmp("R6", "no_adv_partial", adv_seen, 0);
    beat(2, 1, 0, 0, 2, 0, 0, "R6");
    beat(2, 2, 0, 0, 2, 0, 0, "R6");
    beat(2, 3, 0, 0, 2, 0, 0, "R6");
    cmp("R6", "adv_after_full", adv_seen, 1);

    // R9: interleaved two-word writes on queues 1 and 3
    beat(1, 0, 1, 0, 1, 0, 0, "R9");
    beat(3, 0, 1, 0, 1, 0, 0, "R9");
    beat(1, 1, 1, 0, 1, 0, 0, "R9");
    beat(3, 1, 1, 0, 1, 0, 0, "R9");

    // R7: six-beat burst on a four-word queue, last two beats dropped
    beat(0, 0, 1, 0, 2, 0, 0, "R7");
    for (int k = 1; k < 6; k++) beat(0, k % 4, 1, 1, 2, 0, 0, "R7");
    // R7: two-word burst continued to slot 0 position 2 is dropped
    beat(1, 0, 0, 0, 1, 0, 0, "R7");
    beat(1, 1, 0, 1, 1, 0, 0, "R7");
    beat(1, 0, 0, 1, 1, 0, 0, "R7");

    // R3: status rejection also clears partial progress
    beat(3, 0, 0, 0, 2, 0, 0, "R3");
    beat(3, 0, 0, 0, 2, 1, 0, "R3");
    beat(3, 1, 0, 0, 2, 0, 0, "R3");
    idle_chk();

    // sweep: every size, direction, slot pair and burst flag
    for (int sz = 0; sz < 4; sz++)
      for (int wr = 0; wr < 2; wr++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int c = 0; c < 2; c++) begin
              beat(1, a, wr, 0, sz, 0, 0, "");
              beat(1, b, wr, c, sz, (a + b) == 5 ? 1 : 0, (a + b) == 6 ? 1 : 0, "");
            end

    // long mixed stream with per-queue sizes
    for (int n = 0; n < 4000; n++) begin
      int q, off, wr, cont;
      q = rnd(NQ);
      if (rnd(64) == 0) cfg[q] = rnd(4);
      wr = m_busy[q] ? (rnd(8) == 0 ? !m_dir[q] : m_dir[q]) : rnd(2);
      off = (m_busy[q] && rnd(10) < 7) ? m_next[q] : rnd(4);
      cont = rnd(2);
      beat(q, off, wr, cont, cfg[q], rnd(6) == 0, rnd(6) == 0, "");
      if (rnd(16) == 0) idle_chk();
    end
    idle_chk();

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule